// File: doc/BRIEF.md
# Programmable memory range decoder

This block sits beside a chipset memory controller and watches each CPU address. It holds a small set of programmable address windows. Each window has a base aligned to 64 KB and a power-of-two size. When the address falls in a window, that window can change how the access is handled:

- it can pull the access out of DRAM, which leaves a hole in DRAM;
- it can claim the cycle for the local bus without waiting for the external device claim;
- it can override how the L1 and L2 caches treat the range.

Every window also drives its own chip-select line.

Software programs the windows through an index/data configuration port. The block is purely combinational from address to attributes. A register write takes effect on the clock edge that captures it. Outside every window, only addresses below the DRAM top input are cacheable. The L1 write policy then follows the default-mode input. When several windows match, the lowest-numbered one sets the attributes.

Top module: `memwin_decoder`

## Requirements
- R1: After reset every window register reads 0, every chip select is low, and no attribute override applies.
- R2: Window w owns configuration indices 0x30+4w to 0x33+4w, and each index holds one byte:
  - +0 holds base address bits 23..16 and +1 holds base address bits 31..24.
  - +2 holds the control byte: bits 1:0 are the cache attribute, bit 2 forces the local-bus claim, bit 3 punches a DRAM hole.
  - +3 holds the size byte: bits 3:0 are the size code and bit 7 enables the window.
  - Unused bits read 0. Indices outside the windows read 0 and ignore writes.
  - A write is visible from the clock edge that captures it.
- R3: An enabled window with size code n covers 64 KB × 2^n. Base bits below bit 16+n are ignored. Chip select cs_o[w] is high exactly while the address lies in window w. A disabled window never drives it.
- R4: With no window matching:
  - dram_sel, l1_cache and l2_cache equal (addr < dram_top);
  - l1_wb equals dflt_wb;
  - local_claim equals ext_local.
- R5: A matching window with the hole bit set forces dram_sel, l1_cache and l2_cache low.
- R6: A matching window with the local bit set forces local_claim high whatever ext_local is. It leaves dram_sel unchanged.
- R7: Cache attribute 01 forces l1_cache and l2_cache low.
- R8: Cache attribute 10 forces l1_cache high and l1_wb low. Attribute 11 forces l1_cache high and l1_wb high. Both apply even outside DRAM, and neither changes l2_cache. Attribute 00 changes nothing.
- R9: When several windows match, the lowest-numbered matching window alone sets the attributes. Each window's chip select still follows its own match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for cfg_idx (combinational) |
| addr | input | ADDR_W | CPU address |
| dram_top | input | ADDR_W | First address above local DRAM |
| dflt_wb | input | 1 | Default L1 mode: 1 write-back, 0 write-through |
| ext_local | input | 1 | External local-device claim, active high |
| cs_o | output | NUM_WIN | Per-window chip select |
| dram_sel | output | 1 | Access is served by DRAM |
| local_claim | output | 1 | Local bus claims the cycle |
| l1_cache | output | 1 | Range may be cached in L1 |
| l2_cache | output | 1 | Range may be cached in L2 |
| l1_wb | output | 1 | L1 write policy: 1 write-back, 0 write-through |

## Verification
The assertions assume that the address, DRAM top and mode inputs are stable around the sampling edge. They also assume that window 0's programmed registers describe the window that its chip select reports. Each property therefore reads the window 0 registers and the outputs in the same cycle.

The bench changes addresses and mode inputs only on falling edges, and issues register writes one at a time. Between scenarios it disables the windows, so every check starts from a known configuration.

// File: rtl/memwin_pkg.sv
`timescale 1ns/1ps
package memwin_pkg;
   localparam int BASE_W = 16;
   localparam int SIZE_W = 4;

   typedef enum logic [1:0] {
      ATTR_DFLT    = 2'b00,
      ATTR_NOCACHE = 2'b01,
      ATTR_L1WT    = 2'b10,
      ATTR_L1WB    = 2'b11
   } cache_attr_e;

   typedef struct packed {
      logic [BASE_W-1:0] base;
      logic [SIZE_W-1:0] size;
      logic              en;
      logic              hole;
      logic              lclaim;
      cache_attr_e       attr;
   } win_cfg_t;
endpackage

// File: rtl/memwin_regs.sv
`timescale 1ns/1ps
module memwin_regs
   import memwin_pkg::*;
#(
   parameter int         NUM_WIN  = 2,
   parameter logic [7:0] IDX_BASE = 8'h30
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [7:0]               cfg_idx,
   input  logic [7:0]               cfg_wdata,
   output logic [7:0]               cfg_rdata,
   output win_cfg_t [NUM_WIN-1:0]   win_q
);
   localparam logic [5:0] GRP0 = IDX_BASE[7:2];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [5:0] GRP = GRP0 + 6'(w);
      logic hit_grp;
      assign hit_grp = cfg_we && (cfg_idx[7:2] == GRP);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q[w] <= '0;
         end else if (hit_grp) begin
            case (cfg_idx[1:0])
               2'd0: win_q[w].base[7:0]  <= cfg_wdata;
               2'd1: win_q[w].base[15:8] <= cfg_wdata;
               2'd2: begin
                  win_q[w].attr   <= cache_attr_e'(cfg_wdata[1:0]);
                  win_q[w].lclaim <= cfg_wdata[2];
                  win_q[w].hole   <= cfg_wdata[3];
               end
               default: begin
                  win_q[w].size <= cfg_wdata[SIZE_W-1:0];
                  win_q[w].en   <= cfg_wdata[7];
               end
            endcase
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (cfg_idx[7:2] == GRP0 + 6'(w)) begin
            case (cfg_idx[1:0])
               2'd0:    cfg_rdata = win_q[w].base[7:0];
               2'd1:    cfg_rdata = win_q[w].base[15:8];
               2'd2:    cfg_rdata = {4'b0, win_q[w].hole, win_q[w].lclaim, win_q[w].attr};
               default: cfg_rdata = {win_q[w].en, 3'b0, 4'(win_q[w].size)};
            endcase
         end
      end
   end
endmodule

// File: rtl/memwin_match.sv
`timescale 1ns/1ps
module memwin_match
   import memwin_pkg::*;
#(
   parameter int NUM_WIN = 2
) (
   input  logic [BASE_W-1:0]        page,
   input  win_cfg_t [NUM_WIN-1:0]   win_q,
   output logic [NUM_WIN-1:0]       hit
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      logic [BASE_W-1:0] keep;
      assign keep   = {BASE_W{1'b1}} << win_q[w].size;
      assign hit[w] = win_q[w].en && (((page ^ win_q[w].base) & keep) == '0);
   end
endmodule

// File: rtl/memwin_resolve.sv
`timescale 1ns/1ps
module memwin_resolve
   import memwin_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int ADDR_W  = 32
) (
   input  logic [ADDR_W-1:0]        addr,
   input  logic [ADDR_W-1:0]        dram_top,
   input  logic                     dflt_wb,
   input  logic                     ext_local,
   input  win_cfg_t [NUM_WIN-1:0]   win_q,
   input  logic [NUM_WIN-1:0]       hit,
   output logic                     dram_sel,
   output logic                     local_claim,
   output logic                     l1_cache,
   output logic                     l2_cache,
   output logic                     l1_wb
);
   win_cfg_t    sel;
   logic        any;
   logic        in_dram;
   logic        hole;
   cache_attr_e attr;

   always_comb begin
      any = 1'b0;
      sel = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hit[w]) begin
            any = 1'b1;
            sel = win_q[w];
         end
      end
   end

   assign in_dram = addr < dram_top;
   assign hole    = any && sel.hole;
   assign attr    = any ? sel.attr : ATTR_DFLT;

   assign dram_sel    = in_dram && !hole;
   assign local_claim = (any && sel.lclaim) || ext_local;
   assign l2_cache    = in_dram && !hole && (attr != ATTR_NOCACHE);

   always_comb begin
      l1_cache = in_dram;
      l1_wb    = dflt_wb;
      case (attr)
         ATTR_NOCACHE: l1_cache = 1'b0;
         ATTR_L1WT: begin l1_cache = 1'b1; l1_wb = 1'b0; end
         ATTR_L1WB: begin l1_cache = 1'b1; l1_wb = 1'b1; end
         default: ;
      endcase
      if (hole) l1_cache = 1'b0;
   end
endmodule

// File: rtl/memwin_decoder.sv
`timescale 1ns/1ps
module memwin_decoder
   import memwin_pkg::*;
#(
   parameter int         NUM_WIN  = 2,
   parameter int         ADDR_W   = 32,
   parameter int         GRAN_LSB = 16,
   parameter logic [7:0] IDX_BASE = 8'h30
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [7:0]         cfg_idx,
   input  logic [7:0]         cfg_wdata,
   output logic [7:0]         cfg_rdata,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ADDR_W-1:0]  dram_top,
   input  logic               dflt_wb,
   input  logic               ext_local,
   output logic [NUM_WIN-1:0] cs_o,
   output logic               dram_sel,
   output logic               local_claim,
   output logic               l1_cache,
   output logic               l2_cache,
   output logic               l1_wb
);
   localparam int PAGE_W = ADDR_W - GRAN_LSB;

   if (PAGE_W != BASE_W) begin : g_bad_width
      $error("memwin_decoder: ADDR_W - GRAN_LSB must equal the two-byte base field");
   end
   if (NUM_WIN < 1 || NUM_WIN > 4) begin : g_bad_count
      $error("memwin_decoder: NUM_WIN must be 1 to 4");
   end
   if (IDX_BASE[1:0] != 2'b00) begin : g_bad_index
      $error("memwin_decoder: IDX_BASE must be a multiple of 4");
   end

   win_cfg_t [NUM_WIN-1:0] win_q;

   memwin_regs #(.NUM_WIN(NUM_WIN), .IDX_BASE(IDX_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_q(win_q)
   );

   memwin_match #(.NUM_WIN(NUM_WIN)) u_match (
      .page(addr[ADDR_W-1:GRAN_LSB]), .win_q(win_q), .hit(cs_o)
   );

   memwin_resolve #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_resolve (
      .addr(addr), .dram_top(dram_top), .dflt_wb(dflt_wb), .ext_local(ext_local),
      .win_q(win_q), .hit(cs_o), .dram_sel(dram_sel), .local_claim(local_claim),
      .l1_cache(l1_cache), .l2_cache(l2_cache), .l1_wb(l1_wb)
   );
endmodule

// File: rtl/memwin_chk.sv
`timescale 1ns/1ps
module memwin_chk
   import memwin_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int ADDR_W  = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        addr,
   input logic [ADDR_W-1:0]        dram_top,
   input logic [NUM_WIN-1:0]       cs_o,
   input logic                     dram_sel,
   input logic                     local_claim,
   input logic                     l1_cache,
   input logic                     l2_cache,
   input logic                     l1_wb,
   input win_cfg_t [NUM_WIN-1:0]   win_q
);
   AST_OFF_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !win_q[0].en |-> !cs_o[0]); // R3
   AST_L2_DRAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (addr >= dram_top) |-> !l2_cache && !dram_sel); // R4
   AST_HOLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_o[0] && win_q[0].hole) |-> !dram_sel && !l1_cache && !l2_cache); // R5
   AST_LOCAL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_o[0] && win_q[0].lclaim) |-> local_claim); // R6
   AST_NOCACHE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_o[0] && win_q[0].attr == ATTR_NOCACHE) |-> !l1_cache && !l2_cache); // R7
   AST_L1_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_o[0] && !win_q[0].hole && win_q[0].attr[1]) |-> l1_cache && (l1_wb == win_q[0].attr[0])); // R8
endmodule

bind memwin_decoder memwin_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .dram_top(dram_top), .cs_o(cs_o),
   .dram_sel(dram_sel), .local_claim(local_claim), .l1_cache(l1_cache),
   .l2_cache(l2_cache), .l1_wb(l1_wb), .win_q(win_q)
);

// File: tb/test_memwin_decoder.sv
`timescale 1ns/1ps
module test_memwin_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [31:0] addr = '0;
   logic [31:0] dram_top = 32'h0100_0000;
   logic        dflt_wb = 1'b1;
   logic        ext_local = 1'b0;
   logic [1:0]  cs_o;
   logic        dram_sel, local_claim, l1_cache, l2_cache, l1_wb;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   memwin_decoder i_memwin_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr(addr),
      .dram_top(dram_top), .dflt_wb(dflt_wb), .ext_local(ext_local),
      .cs_o(cs_o), .dram_sel(dram_sel), .local_claim(local_claim),
      .l1_cache(l1_cache), .l2_cache(l2_cache), .l1_wb(l1_wb)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] idx, input logic [7:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] idx, input logic [7:0] exp);
      cfg_idx = idx;
      #1;
      chk(tag, {24'b0, cfg_rdata}, {24'b0, exp});
   endtask

   task automatic set_win(input int w, input logic [15:0] base, input logic [7:0] ctrl,
                          input logic [3:0] size);
      wr(8'h30 + 8'(4*w), base[7:0]);
      wr(8'h31 + 8'(4*w), base[15:8]);
      wr(8'h32 + 8'(4*w), ctrl);
      wr(8'h33 + 8'(4*w), {4'h8, size});
   endtask

   task automatic clear_all();
      wr(8'h33, 8'h00);
      wr(8'h37, 8'h00);
      wr(8'h32, 8'h00);
      wr(8'h36, 8'h00);
   endtask

   task automatic at(input logic [31:0] a);
      @(negedge clk);
      addr = a;
      #1;
   endtask

   task automatic t_reset();
      for (int i = 0; i < 8; i++) rd_chk("R1 readback", 8'h30 + 8'(i), 8'h00);
      at(32'h0000_0000);
      chk("R1 cs", {30'b0, cs_o}, 32'h0);
      chk("R1 dram_sel", {31'b0, dram_sel}, 32'h1);
      chk("R1 l1_wb", {31'b0, l1_wb}, 32'h1);
   endtask

   task automatic t_regs();
      wr(8'h30, 8'hAB);
      wr(8'h31, 8'hCD);
      wr(8'h32, 8'hFF);
      wr(8'h33, 8'hFF);
      wr(8'h38, 8'h55);
      wr(8'h2F, 8'h55);
      rd_chk("R2 base lo", 8'h30, 8'hAB);
      rd_chk("R2 base hi", 8'h31, 8'hCD);
      rd_chk("R2 ctrl unused bits", 8'h32, 8'h0F);
      rd_chk("R2 size unused bits", 8'h33, 8'h8F);
      rd_chk("R2 outside index", 8'h38, 8'h00);
      rd_chk("R2 below index", 8'h2F, 8'h00);
      rd_chk("R2 window1 untouched", 8'h34, 8'h00);
      for (int i = 0; i < 4; i++) wr(8'h30 + 8'(i), 8'h00);
      rd_chk("R2 cleared", 8'h33, 8'h00);
   endtask

   task automatic t_match();
      set_win(0, 16'h0013, 8'h00, 4'd1);
      at(32'h0012_0000); chk("R3 low edge", {30'b0, cs_o}, 32'h1);
      at(32'h0013_FFFF); chk("R3 high edge", {30'b0, cs_o}, 32'h1);
      at(32'h0014_0000); chk("R3 above", {30'b0, cs_o}, 32'h0);
      at(32'h0011_FFFF); chk("R3 below", {30'b0, cs_o}, 32'h0);
      at(32'h0012_8000);
      chk("R4 attr 00 l1", {31'b0, l1_cache}, 32'h1);
      chk("R4 attr 00 l2", {31'b0, l2_cache}, 32'h1);
      wr(8'h33, 8'h01);
      #1;
      chk("R3 disabled", {30'b0, cs_o}, 32'h0);
      clear_all();
   endtask

   task automatic t_default();
      at(32'h0100_0000);
      chk("R4 top dram", {31'b0, dram_sel}, 32'h0);
      chk("R4 top l1", {31'b0, l1_cache}, 32'h0);
      chk("R4 top l2", {31'b0, l2_cache}, 32'h0);
      at(32'h00FF_FFFF);
      chk("R4 below top", {31'b0, l2_cache}, 32'h1);
      dflt_wb = 1'b0; ext_local = 1'b1; #1;
      chk("R4 dflt wt", {31'b0, l1_wb}, 32'h0);
      chk("R4 ext local", {31'b0, local_claim}, 32'h1);
      dflt_wb = 1'b1; ext_local = 1'b0; #1;
      chk("R4 ext local off", {31'b0, local_claim}, 32'h0);
   endtask

   task automatic t_hole();
      set_win(1, 16'h0020, 8'h08, 4'd0);
      at(32'h0020_1000);
      chk("R5 cs1", {30'b0, cs_o}, 32'h2);
      chk("R5 dram", {31'b0, dram_sel}, 32'h0);
      chk("R5 l1", {31'b0, l1_cache}, 32'h0);
      chk("R5 l2", {31'b0, l2_cache}, 32'h0);
      at(32'h0021_0000);
      chk("R5 outside", {31'b0, dram_sel}, 32'h1);
      clear_all();
   endtask

   task automatic t_local();
      set_win(0, 16'h0030, 8'h04, 4'd0);
      at(32'h0030_0000);
      chk("R6 forced", {31'b0, local_claim}, 32'h1);
      chk("R6 dram kept", {31'b0, dram_sel}, 32'h1);
      at(32'h0031_0000);
      chk("R6 outside", {31'b0, local_claim}, 32'h0);
      clear_all();
   endtask

   task automatic t_nocache();
      set_win(0, 16'h0040, 8'h01, 4'd2);
      at(32'h0043_0000);
      chk("R7 l1", {31'b0, l1_cache}, 32'h0);
      chk("R7 l2", {31'b0, l2_cache}, 32'h0);
      chk("R7 dram kept", {31'b0, dram_sel}, 32'h1);
      clear_all();
   endtask

   task automatic t_l1force();
      set_win(0, 16'h8000, 8'h02, 4'd0);
      at(32'h8000_1234);
      chk("R8 wt l1", {31'b0, l1_cache}, 32'h1);
      chk("R8 wt mode", {31'b0, l1_wb}, 32'h0);
      chk("R8 wt l2", {31'b0, l2_cache}, 32'h0);
      chk("R8 wt dram", {31'b0, dram_sel}, 32'h0);
      dflt_wb = 1'b0;
      wr(8'h32, 8'h03);
      #1;
      chk("R8 wb mode", {31'b0, l1_wb}, 32'h1);
      dflt_wb = 1'b1;
      set_win(0, 16'h0050, 8'h02, 4'd0);
      at(32'h0050_0000);
      chk("R8 wt in dram", {31'b0, l1_wb}, 32'h0);
      chk("R8 l2 kept", {31'b0, l2_cache}, 32'h1);
      clear_all();
   endtask

   task automatic t_prio();
      set_win(0, 16'h0060, 8'h01, 4'd1);
      set_win(1, 16'h0060, 8'h0B, 4'd0);
      at(32'h0060_0000);
      chk("R9 both cs", {30'b0, cs_o}, 32'h3);
      chk("R9 win0 dram", {31'b0, dram_sel}, 32'h1);
      chk("R9 win0 l2", {31'b0, l2_cache}, 32'h0);
      at(32'h0061_0000);
      chk("R9 only win0 cs", {30'b0, cs_o}, 32'h1);
      wr(8'h33, 8'h00);
      at(32'h0060_0000);
      chk("R9 win1 hole", {31'b0, dram_sel}, 32'h0);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_match();
      t_default();
      t_hole();
      t_local();
      t_nocache();
      t_l1force();
      t_prio();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule